// File: doc/BRIEF.md
# Serial Receive Channel with Four-Character Buffer

This block is one asynchronous serial receive channel. It watches a single serial input line, finds start bits, assembles characters of five to eight data bits with an optional parity or address bit, and queues each finished character in a small buffer together with its error flags. A host reads characters through a one-cycle read strobe. It sees the character at the head of the queue, with that character's flags, on parallel outputs.

Sampling follows a tick input. In oversampled mode each tick is one of sixteen samples per bit. In direct mode each tick is the rising edge of a one-per-bit clock. The block reports when data is ready and when the holding queue is full. It keeps a sticky overrun flag, marks the start and end of a line break with pulses, and can drive an active-low request-to-send output that tells a remote sender to pause while the queue is full. In multidrop operation it discards traffic until an address character arrives.

Top module: `uart_rx_quad`

## Requirements
- R1: Bits arrive least significant first after a low start bit. `len_i` selects the data length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. `data_o` shows the character with every bit above the selected length at zero.
- R2: `par_mode_i` selects the bit that follows the data. 0 means no parity bit. 1 means even parity, 2 means odd parity, and 3 means the bit must equal `par_force_i`. A mismatch sets `perr_o` for that character.
- R3: If the stop bit is sampled low and the character is not entirely zero, the entry is stored with `ferr_o` set.
- R4: The block holds at most four characters: three in the queue and one waiting behind it. `ready_o` is high while the queue holds at least one entry, and `full_o` is high while it holds three. Characters are read out in arrival order, one per `rd_i` pulse.
- R5: A character that completes while four are already held is dropped and sets `overrun_o`. The flag survives data reads and is cleared only by `clr_err_i`.
- R6: With `auto_rts_i` high, `rts_n_o` is high while the queue is full and low once a slot is free. With `auto_rts_i` low, `rts_n_o` stays low.
- R7: In oversampled mode (`x1_mode_i` = 0), a start bit counts only after 8 consecutive low samples. A shorter low pulse produces no character.
- R8: A frame that is low from its start bit through its stop bit is stored as one entry with data 0, `brk_o` and `ferr_o` set. It also gives a one-cycle `brk_begin_o` pulse. When the line next returns high, a one-cycle `brk_end_o` pulse follows. A break that begins in the middle of a character first yields that character with `ferr_o`, and then the break entry.
- R9: With `wake_i` high, the bit after the data is an address flag and `par_mode_i` is ignored. Characters with the flag at 0 are discarded until one arrives with the flag at 1. From then on all characters are stored. `addr_o` shows the flag of the head entry.
- R10: In direct mode (`x1_mode_i` = 1), every tick samples exactly one bit, and a single low sample starts a character.
- R11: After reset, `ready_o`, `full_o`, `overrun_o`, `rts_n_o`, `brk_begin_o` and `brk_end_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| rx_en_i | input | 1 | Receiver enable |
| tick_i | input | 1 | Sample tick (16x sample, or 1x bit edge) |
| x1_mode_i | input | 1 | 1: each tick is a bit; 0: 16 ticks per bit |
| rxd_i | input | 1 | Serial data in, idle high |
| len_i | input | 2 | Data length code, 5 + value bits |
| par_mode_i | input | 2 | Parity selection |
| par_force_i | input | 1 | Required value of the forced parity bit |
| wake_i | input | 1 | Multidrop address-filter mode |
| auto_rts_i | input | 1 | Enables automatic request-to-send pacing |
| rd_i | input | 1 | Pops the head entry |
| clr_err_i | input | 1 | Clears the overrun flag |
| data_o | output | 8 | Head entry data |
| perr_o | output | 1 | Head entry parity error |
| ferr_o | output | 1 | Head entry framing error |
| brk_o | output | 1 | Head entry is a break |
| addr_o | output | 1 | Head entry address flag |
| ready_o | output | 1 | At least one entry queued |
| full_o | output | 1 | Queue holds three entries |
| overrun_o | output | 1 | Sticky overrun flag |
| rts_n_o | output | 1 | Request-to-send, active low |
| brk_begin_o | output | 1 | Pulse when a break is detected |
| brk_end_o | output | 1 | Pulse when a break ends |

## Verification
The hardest condition to reach is a break that begins partway through a character. The stimulus sends a start bit and two high data bits, then pulls the line low for many bit times. This forces a framing error, a re-qualified start inside the low period, and an all-zero break frame, in that order. Overrun is the next hardest: five characters are sent back to back with no reads, and then the four held entries are drained one at a time. The drain shows the waiting slot refilling the queue while request-to-send stays high, and it confirms that the overrun flag outlasts every read.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned MINB   = DATA_W - 3;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              perr;
        logic              ferr;
        logic              brk;
        logic              addr;
    } rx_entry_t;

    typedef enum logic [2:0] {
        S_HUNT, S_DATA, S_XBIT, S_STOP, S_BRK
    } rx_state_t;
endpackage

// File: rtl/rxq_frame.sv
module rxq_frame
    import rxq_pkg::*;
#(
    parameter int unsigned OSR = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      en_i,
    input  logic      tick_i,
    input  logic      x1_i,
    input  logic      rxd_i,
    input  logic [1:0] len_i,
    input  logic [1:0] par_i,
    input  logic      force_i,
    input  logic      wake_i,
    output logic      char_v_o,
    output rx_entry_t char_o,
    output logic      brk_begin_o,
    output logic      brk_end_o
);
    localparam int unsigned CW   = $clog2(OSR);
    localparam int unsigned HALF = OSR / 2;
    localparam int unsigned IW   = $clog2(DATA_W);

    typedef struct packed {
        rx_state_t         st;
        logic [CW-1:0]     cnt;
        logic [IW-1:0]     idx;
        logic [DATA_W-1:0] sh;
        logic              nz;
        logic              pbit;
        logic              v;
        rx_entry_t         ent;
        logic              bb;
        logic              be;
    } frame_t;

    frame_t q, n;
    logic samp, pe;
    logic [3:0] shamt;
    logic [DATA_W-1:0] got;

    always_comb begin
        n      = q;
        n.v    = 1'b0;
        n.bb   = 1'b0;
        n.be   = 1'b0;
        samp   = tick_i && (x1_i || q.cnt == CW'(OSR - 1));
        shamt  = 4'(DATA_W - MINB) - {2'b00, len_i};
        got    = q.sh >> shamt;
        case (par_i)
            2'b01:   pe = (^got) ^ q.pbit;
            2'b10:   pe = ~((^got) ^ q.pbit);
            2'b11:   pe = q.pbit ^ force_i;
            default: pe = 1'b0;
        endcase
        if ((q.st == S_DATA || q.st == S_XBIT || q.st == S_STOP) && tick_i && !x1_i)
            n.cnt = (q.cnt == CW'(OSR - 1)) ? '0 : q.cnt + 1'b1;
        case (q.st)
            S_HUNT: if (tick_i) begin
                if (!rxd_i) begin
                    if (x1_i || q.cnt == CW'(HALF - 1)) begin
                        n.st  = S_DATA;
                        n.cnt = '0;
                        n.idx = '0;
                        n.nz  = 1'b0;
                        n.sh  = '0;
                    end else begin
                        n.cnt = q.cnt + 1'b1;
                    end
                end else begin
                    n.cnt = '0;
                end
            end
            S_DATA: if (samp) begin
                n.sh  = {rxd_i, q.sh[DATA_W-1:1]};
                n.nz  = q.nz | rxd_i;
                n.idx = q.idx + 1'b1;
                if (q.idx == IW'(len_i) + IW'(MINB - 1))
                    n.st = (wake_i || par_i != 2'b00) ? S_XBIT : S_STOP;
            end
            S_XBIT: if (samp) begin
                n.pbit = rxd_i;
                n.nz   = q.nz | rxd_i;
                n.st   = S_STOP;
            end
            S_STOP: if (samp) begin
                n.v        = 1'b1;
                n.ent.data = got;
                n.ent.perr = !wake_i && pe;
                n.ent.ferr = !rxd_i;
                n.ent.brk  = !q.nz && !rxd_i;
                n.ent.addr = wake_i && q.pbit;
                n.cnt      = '0;
                if (!q.nz && !rxd_i) begin
                    n.st = S_BRK;
                    n.bb = 1'b1;
                end else begin
                    n.st = S_HUNT;
                end
            end
            S_BRK: if (tick_i && rxd_i) begin
                n.be  = 1'b1;
                n.st  = S_HUNT;
                n.cnt = '0;
            end
            default: n.st = S_HUNT;
        endcase
        if (!en_i) begin
            n.st  = S_HUNT;
            n.cnt = '0;
            n.v   = 1'b0;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            q    <= '0;
            q.st <= S_HUNT;
        end else begin
            q <= n;
        end
    end

    assign char_v_o    = q.v;
    assign char_o      = q.ent;
    assign brk_begin_o = q.bb;
    assign brk_end_o   = q.be;
endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push_i,
    input  rx_entry_t din_i,
    input  logic      pop_i,
    output rx_entry_t head_o,
    output logic      full_o,
    output logic      empty_o
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned NW = $clog2(DEPTH + 1);

    typedef struct packed {
        rx_entry_t [DEPTH-1:0] mem;
        logic [PW-1:0]         wp;
        logic [PW-1:0]         rp;
        logic [NW-1:0]         cnt;
    } fifo_t;

    fifo_t q, n;
    logic do_pop, do_push;

    always_comb begin
        n       = q;
        do_pop  = pop_i && q.cnt != '0;
        do_push = push_i && (q.cnt != NW'(DEPTH) || do_pop);
        if (do_push) begin
            n.mem[q.wp] = din_i;
            n.wp = (q.wp == PW'(DEPTH - 1)) ? '0 : q.wp + 1'b1;
        end
        if (do_pop)
            n.rp = (q.rp == PW'(DEPTH - 1)) ? '0 : q.rp + 1'b1;
        n.cnt = q.cnt + NW'(do_push) - NW'(do_pop);
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) q <= '0;
        else     q <= n;
    end

    assign head_o  = q.mem[q.rp];
    assign full_o  = q.cnt == NW'(DEPTH);
    assign empty_o = q.cnt == '0;
endmodule

// File: rtl/uart_rx_quad.sv
module uart_rx_quad
    import rxq_pkg::*;
#(
    parameter int unsigned OSR        = 16,
    parameter int unsigned FIFO_DEPTH = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_en_i,
    input  logic       tick_i,
    input  logic       x1_mode_i,
    input  logic       rxd_i,
    input  logic [1:0] len_i,
    input  logic [1:0] par_mode_i,
    input  logic       par_force_i,
    input  logic       wake_i,
    input  logic       auto_rts_i,
    input  logic       rd_i,
    input  logic       clr_err_i,
    output logic [7:0] data_o,
    output logic       perr_o,
    output logic       ferr_o,
    output logic       brk_o,
    output logic       addr_o,
    output logic       ready_o,
    output logic       full_o,
    output logic       overrun_o,
    output logic       rts_n_o,
    output logic       brk_begin_o,
    output logic       brk_end_o
);
    typedef struct packed {
        logic      pend_v;
        rx_entry_t pend;
        logic      ovr;
        logic      awake;
    } top_t;

    top_t q, n;
    logic      f_v, f_full, f_empty, accept, space, push;
    rx_entry_t f_ent, push_data, head;

    rxq_frame #(.OSR(OSR)) u_frame (
        .clk(clk), .rst(rst), .en_i(rx_en_i), .tick_i(tick_i), .x1_i(x1_mode_i),
        .rxd_i(rxd_i), .len_i(len_i), .par_i(par_mode_i), .force_i(par_force_i),
        .wake_i(wake_i), .char_v_o(f_v), .char_o(f_ent),
        .brk_begin_o(brk_begin_o), .brk_end_o(brk_end_o)
    );

    rxq_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push_i(push), .din_i(push_data), .pop_i(rd_i),
        .head_o(head), .full_o(f_full), .empty_o(f_empty)
    );

    always_comb begin
        n         = q;
        push      = 1'b0;
        push_data = q.pend;
        accept    = f_v && (f_ent.brk || !wake_i || f_ent.addr || q.awake);
        space     = !f_full || (rd_i && !f_empty);
        if (clr_err_i) n.ovr = 1'b0;
        if (q.pend_v) begin
            if (space) begin
                push     = 1'b1;
                n.pend_v = accept;
                if (accept) n.pend = f_ent;
            end else if (accept) begin
                n.ovr = 1'b1;
            end
        end else if (accept) begin
            if (space) begin
                push      = 1'b1;
                push_data = f_ent;
            end else begin
                n.pend_v = 1'b1;
                n.pend   = f_ent;
            end
        end
        if (!wake_i || !rx_en_i)     n.awake = 1'b0;
        else if (accept && f_ent.addr) n.awake = 1'b1;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) q <= '0;
        else     q <= n;
    end

    assign data_o    = head.data;
    assign perr_o    = head.perr;
    assign ferr_o    = head.ferr;
    assign brk_o     = head.brk;
    assign addr_o    = head.addr;
    assign ready_o   = !f_empty;
    assign full_o    = f_full;
    assign overrun_o = q.ovr;
    assign rts_n_o   = auto_rts_i && f_full;
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker (
    input logic       clk,
    input logic       rst,
    input logic       auto_rts_i,
    input logic       clr_err_i,
    input logic [7:0] data_o,
    input logic       ferr_o,
    input logic       brk_o,
    input logic       ready_o,
    input logic       full_o,
    input logic       overrun_o,
    input logic       rts_n_o,
    input logic       brk_begin_o,
    input logic       brk_end_o
);
    AST_FULL_HAS_DATA: assert property (@(posedge clk) disable iff (rst)
        full_o |-> ready_o); // R4
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        overrun_o && !clr_err_i |=> overrun_o); // R5
    AST_OVR_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun_o) |-> full_o); // R5
    AST_RTS_ON_FILL: assert property (@(posedge clk) disable iff (rst)
        $rose(full_o) && auto_rts_i |-> rts_n_o); // R6
    AST_RTS_OFF_MANUAL: assert property (@(posedge clk) disable iff (rst)
        !auto_rts_i |-> !rts_n_o); // R6
    AST_BRK_EDGES_APART: assert property (@(posedge clk) disable iff (rst)
        !(brk_begin_o && brk_end_o)); // R8
    AST_BRK_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        brk_begin_o |=> !brk_begin_o); // R8
    AST_BRK_ENTRY_SHAPE: assert property (@(posedge clk) disable iff (rst)
        ready_o && brk_o |-> ferr_o && data_o == 8'h00); // R8
endmodule

bind uart_rx_quad rxq_checker u_chk (
    .clk(clk), .rst(rst), .auto_rts_i(auto_rts_i), .clr_err_i(clr_err_i),
    .data_o(data_o), .ferr_o(ferr_o), .brk_o(brk_o), .ready_o(ready_o),
    .full_o(full_o), .overrun_o(overrun_o), .rts_n_o(rts_n_o),
    .brk_begin_o(brk_begin_o), .brk_end_o(brk_end_o)
);

// File: tb/sim_uart_rx_quad.sv
module sim_uart_rx_quad;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst = 1'b1;
    logic rx_en_i = 1'b1, tick_i = 1'b1, x1_mode_i = 1'b0, rxd_i = 1'b1;
    logic [1:0] len_i = 2'd3, par_mode_i = 2'd0;
    logic par_force_i = 1'b0, wake_i = 1'b0, auto_rts_i = 1'b1, rd_i = 1'b0, clr_err_i = 1'b0;
    logic [7:0] data_o;
    logic perr_o, ferr_o, brk_o, addr_o, ready_o, full_o, overrun_o, rts_n_o, brk_begin_o, brk_end_o;

    int checks = 0, errors = 0, nbb = 0, nbe = 0;
    bit done = 1'b0;

    uart_rx_quad u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (!rst && brk_begin_o) nbb++;
        if (!rst && brk_end_o)   nbe++;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input int nb, input bit hasx, input bit xb,
                        input bit stopv, input int bp);
        rxd_i = 1'b0;
        repeat (bp) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            rxd_i = d[i];
            repeat (bp) @(negedge clk);
        end
        if (hasx) begin
            rxd_i = xb;
            repeat (bp) @(negedge clk);
        end
        rxd_i = stopv;
        repeat (bp) @(negedge clk);
        if (stopv) idle(4);
    endtask

    task automatic pop(input string req, input int d, input bit pe, input bit fe,
                       input bit bk, input bit ad);
        check({req, " ready"}, int'(ready_o), 1);
        check({req, " data"},  int'(data_o), d);
        check({req, " perr"},  int'(perr_o), int'(pe));
        check({req, " ferr"},  int'(ferr_o), int'(fe));
        check({req, " brk"},   int'(brk_o), int'(bk));
        check({req, " addr"},  int'(addr_o), int'(ad));
        rd_i = 1'b1;
        @(negedge clk);
        rd_i = 1'b0;
    endtask

    function automatic bit pbit(input logic [7:0] dm, input int mode, input bit f);
        case (mode)
            1: return ^dm;
            2: return ~^dm;
            default: return f;
        endcase
    endfunction

    initial begin
        logic [7:0] vals [4] = '{8'hA5, 8'h3C, 8'hFF, 8'h00};
        idle(5);
        rst = 1'b0;
        idle(2);
        // R11: reset state
        check("R11 ready", int'(ready_o), 0);
        check("R11 full", int'(full_o), 0);
        check("R11 overrun", int'(overrun_o), 0);
        check("R11 rts_n", int'(rts_n_o), 0);
        check("R11 brk pulses", nbb + nbe, 0);

        // R1 / R2: sweep length, parity mode and data in 16x mode
        for (int l = 0; l < 4; l++) begin
            for (int p = 0; p < 4; p++) begin
                foreach (vals[k]) begin
                    logic [7:0] dm;
                    dm = vals[k] & 8'((1 << (l + 5)) - 1);
                    len_i = 2'(l); par_mode_i = 2'(p); par_force_i = vals[k][1];
                    send(vals[k], l + 5, p != 0, pbit(dm, p, vals[k][1]), 1'b1, 16);
                    pop("R1 R2 sweep", int'(dm), 1'b0, 1'b0, 1'b0, 1'b0);
                end
            end
        end
        // R2: wrong parity bit in every parity mode
        len_i = 2'd3;
        for (int p = 1; p < 4; p++) begin
            par_mode_i = 2'(p); par_force_i = 1'b1;
            send(8'h6B, 8, 1'b1, ~pbit(8'h6B, p, 1'b1), 1'b1, 16);
            pop("R2 parity error", 8'h6B, 1'b1, 1'b0, 1'b0, 1'b0);
        end
        par_mode_i = 2'd0;

        // R10 / R3: direct mode, framing error
        x1_mode_i = 1'b1;
        len_i = 2'd2; par_mode_i = 2'd1;
        send(8'h5A, 7, 1'b1, pbit(8'h5A & 8'h7F, 1, 1'b0), 1'b1, 1);
        pop("R10 direct mode", 8'h5A, 1'b0, 1'b0, 1'b0, 1'b0);
        len_i = 2'd3; par_mode_i = 2'd0;
        send(8'h81, 8, 1'b0, 1'b0, 1'b0, 1);
        rxd_i = 1'b1;
        idle(4);
        pop("R3 framing error", 8'h81, 1'b0, 1'b1, 1'b0, 1'b0);
        x1_mode_i = 1'b0;

        // R7: false start rejected, then valid character
        rxd_i = 1'b0; idle(5); rxd_i = 1'b1; idle(40);
        check("R7 no char after glitch", int'(ready_o), 0);
        send(8'hC3, 8, 1'b0, 1'b0, 1'b1, 16);
        pop("R7 char after glitch", 8'hC3, 1'b0, 1'b0, 1'b0, 1'b0);

        // R8: break from idle
        rxd_i = 1'b0; idle(30 * 16);
        check("R8 begin pulse", nbb, 1);
        check("R8 no end while low", nbe, 0);
        rxd_i = 1'b1; idle(4);
        check("R8 end pulse", nbe, 1);
        pop("R8 break entry", 8'h00, 1'b0, 1'b1, 1'b1, 1'b0);
        check("R8 single entry", int'(ready_o), 0);

        // R8: break beginning mid-character
        send(8'h03, 8, 1'b0, 1'b0, 1'b0, 16);
        idle(30 * 16);
        rxd_i = 1'b1; idle(4);
        pop("R8 mid-char cut", 8'h03, 1'b0, 1'b1, 1'b0, 1'b0);
        pop("R8 mid-char break", 8'h00, 1'b0, 1'b1, 1'b1, 1'b0);
        check("R8 mid begin count", nbb, 2);
        check("R8 mid end count", nbe, 2);

        // R4 / R5 / R6: fill, overrun, drain
        for (int i = 1; i <= 5; i++) begin
            send(8'(i * 8'h11), 8, 1'b0, 1'b0, 1'b1, 16);
            if (i == 3) begin
                check("R4 full at three", int'(full_o), 1);
                check("R6 rts negated when full", int'(rts_n_o), 1);
                check("R5 no overrun yet", int'(overrun_o), 0);
            end
            if (i == 4) check("R5 fourth held", int'(overrun_o), 0);
        end
        check("R5 overrun set", int'(overrun_o), 1);
        pop("R4 order 1", 8'h11, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R4 held char refills", int'(full_o), 1);
        check("R6 rts stays negated", int'(rts_n_o), 1);
        pop("R4 order 2", 8'h22, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R6 rts reasserted", int'(rts_n_o), 0);
        auto_rts_i = 1'b0;
        pop("R4 order 3", 8'h33, 1'b0, 1'b0, 1'b0, 1'b0);
        pop("R4 order 4", 8'h44, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R4 empty after four", int'(ready_o), 0);
        check("R5 overrun survives reads", int'(overrun_o), 1);
        clr_err_i = 1'b1; @(negedge clk); clr_err_i = 1'b0;
        check("R5 overrun cleared", int'(overrun_o), 0);

        // R6: manual mode keeps rts low when full
        for (int i = 0; i < 3; i++) send(8'h70 + 8'(i), 8, 1'b0, 1'b0, 1'b1, 16);
        check("R6 manual rts low", int'(rts_n_o), 0);
        for (int i = 0; i < 3; i++) pop("R6 drain", 8'h70 + i, 1'b0, 1'b0, 1'b0, 1'b0);

        // R9: multidrop filtering
        wake_i = 1'b1; par_mode_i = 2'd1;
        send(8'h21, 8, 1'b1, 1'b0, 1'b1, 16);
        check("R9 data before address ignored", int'(ready_o), 0);
        send(8'h42, 8, 1'b1, 1'b1, 1'b1, 16);
        send(8'h13, 8, 1'b1, 1'b0, 1'b1, 16);
        pop("R9 address entry", 8'h42, 1'b0, 1'b0, 1'b0, 1'b1);
        pop("R9 data after address", 8'h13, 1'b0, 1'b0, 1'b0, 1'b0);
        wake_i = 1'b0; par_mode_i = 2'd0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule